// File: doc/BRIEF.md
# Display-Enable Latch and Load Generator

This block sits after a horizontal sequencer that supplies a window flag and a running cycle position within each scanline. It samples the window flag only at a small set of fixed cycle positions and holds a registered display-enable between them. Because DE can move only at these slots, the number of bytes fetched on a line comes in a few set lengths, such as 0, 54, 56, 80, 158, 160, 162, 184, 186, 204, 206 and 230. The phase of the sequencer does not shift these slots.

When DE is high at the fixed detection slot, the block sends a single load strobe to the pixel shifter. After a fixed fetch-plus-pipeline delay it raises a first-pixel-valid strobe. It also counts fetched bytes, one for every two cycles that DE is high. At each start-of-line pulse it latches the count of the line that just ended, so the length of every line can be checked.

Top module: `de_load_gen`

## Requirements
- R1: When `hWin` is 1 during a cycle whose `cycleCnt` is 8, 56 or 60, `de` is 1 from the next cycle on.
- R2: When `hWin` is 0 during a cycle whose `cycleCnt` is 168, 376 or 380, `de` is 0 from the next cycle on.
- R3: In the cycle after the one whose `cycleCnt` is 468, `de` is 0 whatever `hWin` is (line cut-off), so DE never carries into the next line.
- R4: At every other cycle position `de` keeps its value, whatever `hWin` does.
- R5: `load` is a one-cycle pulse, high exactly in the cycle where `cycleCnt` is 64, and only when `de` was 1 in the cycle where `cycleCnt` is 62. It fires at most once per line.
- R6: `pixValid` is a one-cycle pulse exactly 18 cycles after `load` (cycle 82 of the line).
- R7: The byte counter adds one for each cycle with `de` high and odd `cycleCnt`. On `lineStart` its value goes to `lineBytes` (visible from the next cycle) and the counter restarts. The result is (fall slot − rise slot)/2.
- R8: A line on which DE is never raised reports `lineBytes` = 0.
- R9: While `rst` is high, `de`, `load`, `pixValid` and `lineBytes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| hWin | input | 1 | Horizontal window flag from the sequencer |
| cycleCnt | input | CYC_W (10) | Cycle position within the line |
| lineStart | input | 1 | Start-of-line pulse, in the cycle where `cycleCnt` is 0 |
| de | output | 1 | Registered display enable |
| load | output | 1 | One-cycle load strobe toward the shifter |
| pixValid | output | 1 | First-pixel-valid strobe |
| lineBytes | output | BYTE_W (8) | Bytes fetched on the previous line |

## Verification
The window flag is swept over a grid of opening and closing positions. The grid puts each edge just before, on and just after each sampling slot, and it also covers windows that never open and windows that stay open past the cut-off. Opening at 0, 8 or 9 separates the early rise from the 56 and 60 rises. Closing at 168/169, 376/377 and 380/381 shows whether each fall slot samples the flag in the right cycle. Windows still open at 468 exercise the cut-off and give the longest lines. For every line the bench compares the rise and fall cycles of DE, the load and pixel strobe positions, and the latched byte count against values it works out from the window alone. Together the lines produce every quantised length, including zero.

// File: rtl/de_load_pkg.sv
package de_load_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic dispOn;    // registered display enable
    logic loadPulse; // one-cycle load toward the shifter
    logic lineMark;  // start of a new line
    logic byteTick;  // one fetched byte in this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/de_load_ctrl.sv
module de_load_ctrl
  import de_load_pkg::*;
#(
  parameter int CYC_W    = 10,
  parameter int N_RISE   = 3,
  parameter int RISE_CYC [N_RISE] = '{8, 56, 60},
  parameter int N_FALL   = 3,
  parameter int FALL_CYC [N_FALL] = '{168, 376, 380},
  parameter int CUTOFF   = 468,
  parameter int DETECT   = 62,
  parameter int LOAD_AT  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hWin,
  input  logic [CYC_W-1:0] cycleCnt,
  input  logic             lineStart,
  output ctrlStrobes_t     strobes
);

  localparam logic [CYC_W-1:0] CUT_POS  = CYC_W'(CUTOFF);
  localparam logic [CYC_W-1:0] DET_POS  = CYC_W'(DETECT);
  localparam logic [CYC_W-1:0] FIRE_POS = CYC_W'(LOAD_AT - 1);

  logic [N_RISE-1:0] riseMatch;
  logic [N_FALL-1:0] fallMatch;
  logic              cutHit;
  logic              de;
  logic              loadPend;
  logic              load;

  for (genvar i = 0; i < N_RISE; i++) begin : g_rise
    assign riseMatch[i] = (cycleCnt == CYC_W'(RISE_CYC[i]));
  end

  for (genvar j = 0; j < N_FALL; j++) begin : g_fall
    assign fallMatch[j] = (cycleCnt == CYC_W'(FALL_CYC[j]));
  end

  assign cutHit = (cycleCnt == CUT_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      de <= 1'b0;
    end else if (cutHit) begin
      de <= 1'b0;
    end else if ((|fallMatch) && !hWin) begin
      de <= 1'b0;
    end else if ((|riseMatch) && hWin) begin
      de <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loadPend <= 1'b0;
      load     <= 1'b0;
    end else begin
      load <= 1'b0;
      if (lineStart) begin
        loadPend <= 1'b0;
      end else if ((cycleCnt == DET_POS) && de) begin
        loadPend <= 1'b1;
      end else if ((cycleCnt == FIRE_POS) && loadPend) begin
        loadPend <= 1'b0;
        load     <= 1'b1;
      end
    end
  end

  assign strobes.dispOn    = de;
  assign strobes.loadPulse = load;
  assign strobes.lineMark  = lineStart;
  assign strobes.byteTick  = de && cycleCnt[0];

  AST_DE_RISE_SLOT: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> $past(|riseMatch) && $past(hWin)); // R1

  AST_DE_FALL_SLOT: assert property (@(posedge clk) disable iff (rst)
    $fell(de) |-> $past(|fallMatch) || $past(cutHit)); // R2

  AST_DE_CUTOFF: assert property (@(posedge clk) disable iff (rst)
    $past(cutHit) |-> !de); // R3

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load |=> !load); // R5

endmodule

// File: rtl/de_load_data.sv
module de_load_data
  import de_load_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PIX_LAG = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  output logic [BYTE_W-1:0] lineBytes,
  output logic              pixValid
);

  localparam int LAG_W = $clog2(PIX_LAG + 1);
  localparam logic [LAG_W-1:0] LAG_START = LAG_W'(PIX_LAG - 1);
  localparam logic [LAG_W-1:0] LAG_LAST  = LAG_W'(1);

  logic [BYTE_W-1:0] byteCnt;
  logic [BYTE_W-1:0] tickInc;
  logic [LAG_W-1:0]  lagCnt;

  assign tickInc = BYTE_W'(strobes.byteTick);

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt   <= '0;
      lineBytes <= '0;
    end else if (strobes.lineMark) begin
      lineBytes <= byteCnt + tickInc;
      byteCnt   <= tickInc;
    end else begin
      byteCnt <= byteCnt + tickInc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lagCnt   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= (lagCnt == LAG_LAST);
      if (strobes.loadPulse) begin
        lagCnt <= LAG_START;
      end else if (lagCnt != '0) begin
        lagCnt <= lagCnt - 1'b1;
      end
    end
  end

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(strobes.lineMark) && (byteCnt != $past(byteCnt))
      |-> byteCnt == $past(byteCnt) + 1'b1); // R7

  AST_PIX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pixValid |=> !pixValid); // R6

endmodule

// File: rtl/de_load_gen.sv
module de_load_gen
  import de_load_pkg::*;
#(
  parameter int CYC_W   = 10,
  parameter int BYTE_W  = 8,
  parameter int PIX_LAG = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hWin,
  input  logic [CYC_W-1:0]  cycleCnt,
  input  logic              lineStart,
  output logic              de,
  output logic              load,
  output logic              pixValid,
  output logic [BYTE_W-1:0] lineBytes
);

  ctrlStrobes_t strobes;

  de_load_ctrl #(
    .CYC_W (CYC_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hWin      (hWin),
    .cycleCnt  (cycleCnt),
    .lineStart (lineStart),
    .strobes   (strobes)
  );

  de_load_data #(
    .BYTE_W  (BYTE_W),
    .PIX_LAG (PIX_LAG)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .lineBytes (lineBytes),
    .pixValid  (pixValid)
  );

  assign de   = strobes.dispOn;
  assign load = strobes.loadPulse;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !de && !load && !pixValid && lineBytes == '0); // R9

endmodule

// File: tb/de_load_gen_test.sv
module de_load_gen_test;

  localparam int CYC_W    = 10;
  localparam int BYTE_W   = 8;
  localparam int LINE_LEN = 512;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hWin = 1'b0;
  logic [CYC_W-1:0]  cycleCnt = '0;
  logic              lineStart = 1'b0;
  logic              de;
  logic              load;
  logic              pixValid;
  logic [BYTE_W-1:0] lineBytes;

  int checks = 0;
  int errors = 0;
  int prevBytes = 0;

  always #5 clk = ~clk;

  de_load_gen uut (
    .clk       (clk),
    .rst       (rst),
    .hWin      (hWin),
    .cycleCnt  (cycleCnt),
    .lineStart (lineStart),
    .de        (de),
    .load      (load),
    .pixValid  (pixValid),
    .lineBytes (lineBytes)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit winAt(input int c, input int hOn, input int hOff);
    return (c >= hOn) && (c < hOff);
  endfunction

  task automatic runLine(input int hOn, input int hOff);
    int riseSlots [3] = '{8, 56, 60};
    int fallSlots [3] = '{168, 376, 380};
    int expRise = -1;
    int expFall = -1;
    int expBytes;
    int obsRise = -1;
    int obsFall = -1;
    int deMis = 0;
    int loadN = 0;
    int loadC = -1;
    int pixN = 0;
    int pixC = -1;
    bit expDe;
    for (int k = 0; k < 3; k++)
      if (expRise < 0 && winAt(riseSlots[k], hOn, hOff)) expRise = riseSlots[k];
    if (expRise >= 0) begin
      expFall = 468;
      for (int k = 0; k < 3; k++)
        if (expFall == 468 && !winAt(fallSlots[k], hOn, hOff)) expFall = fallSlots[k];
    end
    expBytes = (expRise >= 0) ? (expFall - expRise) / 2 : 0;
    for (int c = 0; c < LINE_LEN; c++) begin
      @(posedge clk);
      #1;
      cycleCnt  = CYC_W'(c);
      lineStart = (c == 0);
      hWin      = winAt(c, hOn, hOff);
      @(negedge clk);
      expDe = (expRise >= 0) && (c > expRise) && (c <= expFall);
      if (de !== expDe) deMis++;
      if (de === 1'b1) begin
        if (obsRise < 0) obsRise = c - 1;
        obsFall = c;
      end
      if (load === 1'b1) begin loadN++; loadC = c; end
      if (pixValid === 1'b1) begin pixN++; pixC = c; end
      if (c == 1) begin
        if (prevBytes == 0)
          check(lineBytes == 0, "R8 empty line count", int'(lineBytes), 0);
        else
          check(int'(lineBytes) == prevBytes, "R7 latched byte count", int'(lineBytes), prevBytes);
      end
    end
    check(obsRise == expRise, "R1 DE rise slot", obsRise, expRise);
    if (expFall == 468)
      check(obsFall == expFall, "R3 DE cut-off slot", obsFall, expFall);
    else
      check(obsFall == expFall, "R2 DE fall slot", obsFall, expFall);
    check(deMis == 0, "R4 DE holds between slots", deMis, 0);
    check(loadN * 1000 + loadC == ((expRise >= 0) ? 1064 : -1),
          "R5 load pulse", loadN * 1000 + loadC, (expRise >= 0) ? 1064 : -1);
    check(pixN * 1000 + pixC == ((expRise >= 0) ? 1082 : -1),
          "R6 first pixel strobe", pixN * 1000 + pixC, (expRise >= 0) ? 1082 : -1);
    prevBytes = expBytes;
  endtask

  initial begin
    int onList [8]   = '{0, 8, 9, 56, 57, 60, 61, 200};
    int offList [10] = '{9, 57, 100, 168, 169, 376, 377, 380, 381, 470};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(de == 0 && load == 0 && pixValid == 0 && lineBytes == 0,
          "R9 reset state", {29'd0, de, load, pixValid}, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 10; b++)
        runLine(onList[a], offList[b]);
    runLine(0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule